// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block steers a single IDE DMA command through the sequence of buffer chunks that a DMA channel hands over one at a time. When a command is started it works out how many bytes the whole command moves and at which storage byte offset it begins. A fixed-disk command counts 512-byte sectors. A packet (optical) command carries its own byte count and addresses 2048-byte blocks.

Each time the channel presents a chunk, the sequencer picks one outcome. It can issue a storage transfer at the running offset. It can tell the channel to wait until it is restarted. It can retire only the chunk. It can close the whole command, setting a completion status and raising an interrupt. A packet command with no block address is served by a single copy out of the device buffer. The data movement itself happens outside the block. The sequencer only emits the offsets, lengths and handshakes that drive it.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset, active_o, overrun_o and every pulse output are 0, and status_o is 0x00.
- R2: An accepted start (start_i while inactive) makes the command active and sets status_o to 0x80 (busy) one cycle later. The total byte count is start_nsec_i×512 for a disk (start_pkt_i=0) or start_pktsz_i for a packet device (start_pkt_i=1), and the byte index is cleared to 0.
- R3: A chunk with non-zero length, on an active command with bytes remaining, pulses xfer_go_o. xfer_len_o equals the chunk length. xfer_off_o equals start_lba_i<<9 (disk) or start_lba_i<<11 (packet), plus the byte index. The index then grows by the chunk length, and the remaining count shrinks by it, saturating at 0.
- R4: A chunk request while no command is active pulses wait_o and does not pulse chunk_done_o.
- R5: A zero-length chunk on an active command with bytes remaining pulses chunk_done_o only, and the command stays active.
- R6: When a decision finds no bytes remaining, the command ends: chunk_done_o, cmd_done_o and irq_o pulse, and active_o falls. status_o becomes 0x50 (ready plus seek-complete) for a disk or 0x40 (ready) for a packet device.
- R7: A storage completion without error ends the command as in R6 if no bytes remain. Otherwise it pulses chunk_done_o only.
- R8: A storage completion with stor_err_i=1 pulses dma_err_o (disk) or pkt_err_o (packet), together with chunk_done_o, cmd_done_o and irq_o. status_o becomes 0x41, and active_o falls.
- R9: A non-zero-length chunk on a packet command whose start_lba_i was all ones pulses copy_go_o with copy_len_o equal to the smaller of the remaining bytes and the chunk length, and then ends the command as in R6 in the same step.
- R10: Every chunk-completion outcome (R5 to R9) pulses chunk_done_o exactly once. Waiting and issuing a transfer pulse it not at all.
- R11: start_i while active leaves the command, its offsets and status_o unchanged and sets overrun_o. The next accepted start clears overrun_o.
- R12: Every decision appears on the outputs exactly one clock cycle after the request or storage completion that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a command |
| start_pkt_i | input | 1 | 1 = packet device, 0 = disk |
| start_nsec_i | input | NSEC_W | Disk sector count |
| start_lba_i | input | LBA_W | Start sector (disk) or block address (packet) |
| start_pktsz_i | input | PKT_W | Packet transfer byte count |
| chunk_req_i | input | 1 | Channel presents a chunk |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| stor_done_i | input | 1 | Storage operation finished |
| stor_err_i | input | 1 | Storage operation failed |
| xfer_go_o | output | 1 | Issue a storage transfer |
| xfer_off_o | output | OFF_W | Storage byte offset of the transfer |
| xfer_len_o | output | LEN_W | Transfer length |
| copy_go_o | output | 1 | Copy from the device buffer |
| copy_len_o | output | LEN_W | Copy length |
| chunk_done_o | output | 1 | Chunk retired to the channel |
| wait_o | output | 1 | Channel must wait for a restart |
| cmd_done_o | output | 1 | Command finished |
| irq_o | output | 1 | Interrupt pulse |
| dma_err_o | output | 1 | Disk DMA error |
| pkt_err_o | output | 1 | Packet I/O error |
| status_o | output | 8 | Device status byte |
| active_o | output | 1 | Command in progress |
| overrun_o | output | 1 | A start arrived while active |

## Verification
The bench builds the block with its default parameters: an 8-bit sector count, 24-bit addresses, a 20-bit packet size and 16-bit chunk lengths. These widths allow the all-ones "no address" packet case and offsets above 2^32 bytes to be driven directly. They also allow a 1024-byte chunk against a one-sector disk command, which exercises the saturating remaining count. A zero-sector disk command reaches the immediate-end path on its first chunk.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

   localparam logic [7:0] ST_BUSY    = 8'h80;
   localparam logic [7:0] ST_DISK_OK = 8'h50;
   localparam logic [7:0] ST_PKT_OK  = 8'h40;
   localparam logic [7:0] ST_ERR     = 8'h41;

   localparam int DISK_SHIFT = 9;
   localparam int PKT_SHIFT  = 11;

   typedef enum logic [2:0] {
      D_NONE,
      D_WAIT,
      D_END,
      D_CHUNK,
      D_COPY,
      D_XFER,
      D_ERR
   } dec_e;

   typedef enum logic {
      S_IDLE,
      S_STOR
   } state_e;

endpackage

// File: rtl/ide_seq_setup.sv
module ide_seq_setup
   import ide_seq_pkg::*;
#(
   parameter int NSEC_W = 8,
   parameter int LBA_W  = 24,
   parameter int PKT_W  = 20,
   parameter int REM_W  = 20,
   parameter int OFF_W  = 36
)(
   input  logic              pkt_i,
   input  logic [NSEC_W-1:0] nsec_i,
   input  logic [LBA_W-1:0]  lba_i,
   input  logic [PKT_W-1:0]  pktsz_i,
   output logic [REM_W-1:0]  total_o,
   output logic [OFF_W-1:0]  base_o,
   output logic              no_addr_o
);

   localparam int DISK_TOT_W = NSEC_W + DISK_SHIFT;

   if (DISK_TOT_W > REM_W) begin : g_chk_rem_disk
      $error("REM_W too small for the disk byte count");
   end
   if (PKT_W > REM_W) begin : g_chk_rem_pkt
      $error("REM_W too small for the packet byte count");
   end
   if (LBA_W + PKT_SHIFT >= OFF_W) begin : g_chk_off
      $error("OFF_W too small for the scaled block address");
   end

   logic [REM_W-1:0] disk_tot, pkt_tot;
   logic [OFF_W-1:0] disk_base, pkt_base;

   always_comb begin
      disk_tot  = REM_W'(nsec_i) << DISK_SHIFT;
      pkt_tot   = REM_W'(pktsz_i);
      disk_base = OFF_W'(lba_i) << DISK_SHIFT;
      pkt_base  = OFF_W'(lba_i) << PKT_SHIFT;
      total_o   = pkt_i ? pkt_tot  : disk_tot;
      base_o    = pkt_i ? pkt_base : disk_base;
      no_addr_o = pkt_i && (&lba_i);
   end

endmodule

// File: rtl/ide_seq_decide.sv
module ide_seq_decide
   import ide_seq_pkg::*;
(
   input  state_e state_i,
   input  logic   chunk_req_i,
   input  logic   stor_done_i,
   input  logic   stor_err_i,
   input  logic   active_i,
   input  logic   rem_zero_i,
   input  logic   len_zero_i,
   input  logic   no_addr_i,
   output dec_e   dec_o
);

   always_comb begin
      dec_o = D_NONE;
      if (state_i == S_IDLE) begin
         if (chunk_req_i) begin
            if (!active_i)       dec_o = D_WAIT;
            else if (rem_zero_i) dec_o = D_END;
            else if (len_zero_i) dec_o = D_CHUNK;
            else if (no_addr_i)  dec_o = D_COPY;
            else                 dec_o = D_XFER;
         end
      end else if (stor_done_i) begin
         if (stor_err_i)      dec_o = D_ERR;
         else if (rem_zero_i) dec_o = D_END;
         else                 dec_o = D_CHUNK;
      end
   end

endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
   import ide_seq_pkg::*;
#(
   parameter int NSEC_W = 8,
   parameter int LBA_W  = 24,
   parameter int PKT_W  = 20,
   parameter int LEN_W  = 16,
   localparam int REM_W = ((NSEC_W + DISK_SHIFT) > PKT_W) ? (NSEC_W + DISK_SHIFT) : PKT_W,
   localparam int OFF_W = LBA_W + PKT_SHIFT + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              start_pkt_i,
   input  logic [NSEC_W-1:0] start_nsec_i,
   input  logic [LBA_W-1:0]  start_lba_i,
   input  logic [PKT_W-1:0]  start_pktsz_i,
   input  logic              chunk_req_i,
   input  logic [LEN_W-1:0]  chunk_len_i,
   input  logic              stor_done_i,
   input  logic              stor_err_i,
   output logic              xfer_go_o,
   output logic [OFF_W-1:0]  xfer_off_o,
   output logic [LEN_W-1:0]  xfer_len_o,
   output logic              copy_go_o,
   output logic [LEN_W-1:0]  copy_len_o,
   output logic              chunk_done_o,
   output logic              wait_o,
   output logic              cmd_done_o,
   output logic              irq_o,
   output logic              dma_err_o,
   output logic              pkt_err_o,
   output logic [7:0]        status_o,
   output logic              active_o,
   output logic              overrun_o
);

   if (LEN_W > REM_W) begin : g_chk_len
      $error("LEN_W must not exceed the remaining-count width");
   end

   state_e           state;
   logic             active, is_pkt, no_addr, overrun;
   logic [REM_W-1:0] rem, idx;
   logic [OFF_W-1:0] base;
   logic [7:0]       status;

   logic [REM_W-1:0] st_total;
   logic [OFF_W-1:0] st_base;
   logic             st_no_addr;
   dec_e             dec;
   logic [REM_W-1:0] len_ext;
   logic [LEN_W-1:0] copy_len;
   logic             accept;

   ide_seq_setup #(
      .NSEC_W(NSEC_W), .LBA_W(LBA_W), .PKT_W(PKT_W),
      .REM_W(REM_W), .OFF_W(OFF_W)
   ) u_setup (
      .pkt_i    (start_pkt_i),
      .nsec_i   (start_nsec_i),
      .lba_i    (start_lba_i),
      .pktsz_i  (start_pktsz_i),
      .total_o  (st_total),
      .base_o   (st_base),
      .no_addr_o(st_no_addr)
   );

   ide_seq_decide u_decide (
      .state_i    (state),
      .chunk_req_i(chunk_req_i),
      .stor_done_i(stor_done_i),
      .stor_err_i (stor_err_i),
      .active_i   (active),
      .rem_zero_i (rem == '0),
      .len_zero_i (chunk_len_i == '0),
      .no_addr_i  (no_addr),
      .dec_o      (dec)
   );

   always_comb begin
      accept   = start_i && !active;
      len_ext  = REM_W'(chunk_len_i);
      copy_len = (len_ext < rem) ? chunk_len_i : LEN_W'(rem);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         active       <= 1'b0;
         is_pkt       <= 1'b0;
         no_addr      <= 1'b0;
         overrun      <= 1'b0;
         rem          <= '0;
         idx          <= '0;
         base         <= '0;
         status       <= 8'h00;
         xfer_go_o    <= 1'b0;
         xfer_off_o   <= '0;
         xfer_len_o   <= '0;
         copy_go_o    <= 1'b0;
         copy_len_o   <= '0;
         chunk_done_o <= 1'b0;
         wait_o       <= 1'b0;
         cmd_done_o   <= 1'b0;
         irq_o        <= 1'b0;
         dma_err_o    <= 1'b0;
         pkt_err_o    <= 1'b0;
      end else begin
         xfer_go_o    <= 1'b0;
         xfer_off_o   <= '0;
         xfer_len_o   <= '0;
         copy_go_o    <= 1'b0;
         copy_len_o   <= '0;
         chunk_done_o <= 1'b0;
         wait_o       <= 1'b0;
         cmd_done_o   <= 1'b0;
         irq_o        <= 1'b0;
         dma_err_o    <= 1'b0;
         pkt_err_o    <= 1'b0;

         if (start_i && active) begin
            overrun <= 1'b1;
         end

         if (accept) begin
            active  <= 1'b1;
            is_pkt  <= start_pkt_i;
            no_addr <= st_no_addr;
            rem     <= st_total;
            idx     <= '0;
            base    <= st_base;
            status  <= ST_BUSY;
            overrun <= 1'b0;
            state   <= S_IDLE;
         end else begin
            unique case (dec)
               D_WAIT: begin
                  wait_o <= 1'b1;
               end
               D_CHUNK: begin
                  chunk_done_o <= 1'b1;
                  state        <= S_IDLE;
               end
               D_END: begin
                  chunk_done_o <= 1'b1;
                  cmd_done_o   <= 1'b1;
                  irq_o        <= 1'b1;
                  status       <= is_pkt ? ST_PKT_OK : ST_DISK_OK;
                  active       <= 1'b0;
                  state        <= S_IDLE;
               end
               D_COPY: begin
                  copy_go_o    <= 1'b1;
                  copy_len_o   <= copy_len;
                  rem          <= '0;
                  chunk_done_o <= 1'b1;
                  cmd_done_o   <= 1'b1;
                  irq_o        <= 1'b1;
                  status       <= ST_PKT_OK;
                  active       <= 1'b0;
               end
               D_XFER: begin
                  xfer_go_o  <= 1'b1;
                  xfer_off_o <= base + OFF_W'(idx);
                  xfer_len_o <= chunk_len_i;
                  idx        <= idx + len_ext;
                  rem        <= (len_ext >= rem) ? '0 : rem - len_ext;
                  state      <= S_STOR;
               end
               D_ERR: begin
                  dma_err_o    <= !is_pkt;
                  pkt_err_o    <= is_pkt;
                  chunk_done_o <= 1'b1;
                  cmd_done_o   <= 1'b1;
                  irq_o        <= 1'b1;
                  status       <= ST_ERR;
                  active       <= 1'b0;
                  state        <= S_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assign status_o  = status;
   assign active_o  = active;
   assign overrun_o = overrun;

   // R4: a wait is only ever signalled for an inactive command
   a_r4_wait_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |-> !active_o);

   // R10: completion, wait and transfer issue are mutually exclusive
   a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({chunk_done_o, wait_o, xfer_go_o}));

   // R6: an interrupt always accompanies the end of the command
   a_r6_irq_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (!active_o && chunk_done_o && cmd_done_o));

   // R8: error pulses carry the error status
   a_r8_err_status: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_err_o || pkt_err_o) |-> (status_o == ST_ERR && !active_o));

   // R11: overrun only rises after a start that met an active command
   a_r11_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> ($past(active_o) && $past(start_i)));

   // R3: a transfer is issued only for an active command and then awaits storage
   a_r3_xfer_active: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go_o |-> (active_o && state == S_STOR));

   // R12: a storage completion is answered on the very next cycle
   a_r12_stor_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_STOR && stor_done_i && !start_i) |=> chunk_done_o);

endmodule

// File: tb/ide_dma_seq_bench.sv
module ide_dma_seq_bench;

   localparam int NSEC_W = 8;
   localparam int LBA_W  = 24;
   localparam int PKT_W  = 20;
   localparam int LEN_W  = 16;
   localparam int OFF_W  = LBA_W + 12;
   localparam int EV_W   = 8 + 8 + 1 + OFF_W + 2*LEN_W;

   typedef struct {
      logic [EV_W-1:0] ev;
      string           tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0, start_pkt_i = 1'b0;
   logic [NSEC_W-1:0] start_nsec_i = '0;
   logic [LBA_W-1:0]  start_lba_i = '0;
   logic [PKT_W-1:0]  start_pktsz_i = '0;
   logic              chunk_req_i = 1'b0;
   logic [LEN_W-1:0]  chunk_len_i = '0;
   logic              stor_done_i = 1'b0, stor_err_i = 1'b0;
   logic              xfer_go_o, copy_go_o, chunk_done_o, wait_o, cmd_done_o;
   logic              irq_o, dma_err_o, pkt_err_o, active_o, overrun_o;
   logic [OFF_W-1:0]  xfer_off_o;
   logic [LEN_W-1:0]  xfer_len_o, copy_len_o;
   logic [7:0]        status_o;

   int   n_checks = 0;
   int   n_fails  = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   ide_dma_seq u_ide_dma_seq (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_i), .start_pkt_i(start_pkt_i), .start_nsec_i(start_nsec_i),
      .start_lba_i(start_lba_i), .start_pktsz_i(start_pktsz_i),
      .chunk_req_i(chunk_req_i), .chunk_len_i(chunk_len_i),
      .stor_done_i(stor_done_i), .stor_err_i(stor_err_i),
      .xfer_go_o(xfer_go_o), .xfer_off_o(xfer_off_o), .xfer_len_o(xfer_len_o),
      .copy_go_o(copy_go_o), .copy_len_o(copy_len_o),
      .chunk_done_o(chunk_done_o), .wait_o(wait_o), .cmd_done_o(cmd_done_o),
      .irq_o(irq_o), .dma_err_o(dma_err_o), .pkt_err_o(pkt_err_o),
      .status_o(status_o), .active_o(active_o), .overrun_o(overrun_o)
   );

   // flags order: chunk_done, wait, xfer, copy, irq, cmd_done, dma_err, pkt_err
   function automatic logic [EV_W-1:0] mk(logic [7:0] flags, logic [7:0] st,
                                          logic act, logic [OFF_W-1:0] off,
                                          logic [LEN_W-1:0] xl, logic [LEN_W-1:0] cl);
      return {flags, st, act, off, xl, cl};
   endfunction

   function automatic logic [EV_W-1:0] observed();
      return mk({chunk_done_o, wait_o, xfer_go_o, copy_go_o, irq_o, cmd_done_o,
                 dma_err_o, pkt_err_o}, status_o, active_o, xfer_off_o,
                xfer_len_o, copy_len_o);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (chunk_done_o || wait_o || xfer_go_o || copy_go_o || irq_o ||
                    dma_err_o || pkt_err_o)) begin
         n_checks++;
         if (q.size() == 0) begin
            n_fails++;
            $display("FAIL R10: unexpected event actual 0x%0h expected none", observed());
         end else begin
            exp_t e;
            e = q.pop_front();
            if (observed() !== e.ev) begin
               n_fails++;
               $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, observed(), e.ev);
            end
         end
      end
   end

   task automatic do_start(logic pkt, logic [NSEC_W-1:0] ns, logic [LBA_W-1:0] lba,
                           logic [PKT_W-1:0] psz);
      @(negedge clk);
      start_i = 1'b1; start_pkt_i = pkt; start_nsec_i = ns;
      start_lba_i = lba; start_pktsz_i = psz;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic do_chunk(logic [LEN_W-1:0] len, logic [EV_W-1:0] ev, string tag);
      @(negedge clk);
      q.push_back('{ev: ev, tag: tag});
      chunk_req_i = 1'b1; chunk_len_i = len;
      @(negedge clk);
      chunk_req_i = 1'b0; chunk_len_i = '0;
   endtask

   task automatic do_stor(logic err, logic [EV_W-1:0] ev, string tag);
      @(negedge clk);
      q.push_back('{ev: ev, tag: tag});
      stor_done_i = 1'b1; stor_err_i = err;
      @(negedge clk);
      stor_done_i = 1'b0; stor_err_i = 1'b0;
   endtask

   localparam logic [7:0] F_CHUNK = 8'b1000_0000;
   localparam logic [7:0] F_WAIT  = 8'b0100_0000;
   localparam logic [7:0] F_XFER  = 8'b0010_0000;
   localparam logic [7:0] F_END   = 8'b1000_1100;
   localparam logic [7:0] F_COPY  = 8'b1001_1100;
   localparam logic [7:0] F_DERR  = 8'b1000_1110;
   localparam logic [7:0] F_PERR  = 8'b1000_1101;

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", 64'(status_o), 64'h00);
      check("R1 active", 64'(active_o), 0);
      check("R1 overrun", 64'(overrun_o), 0);
      check("R1 pulses", 64'({chunk_done_o, wait_o, xfer_go_o, irq_o}), 0);

      // R4 chunk with nothing active
      do_chunk(16'd512, mk(F_WAIT, 8'h00, 1'b0, '0, '0, '0), "R4 wait idle");

      // disk: 2 sectors at sector 5 -> base 2560 (R2, R3)
      do_start(1'b0, 8'd2, 24'd5, 20'd0);
      check("R2 busy status", 64'(status_o), 64'h80);
      check("R2 active", 64'(active_o), 1);
      do_chunk(16'd512, mk(F_XFER, 8'h80, 1'b1, 36'd2560, 16'd512, '0), "R3 disk offset");
      do_stor(1'b0, mk(F_CHUNK, 8'h80, 1'b1, '0, '0, '0), "R7 chunk only");
      do_chunk(16'd0, mk(F_CHUNK, 8'h80, 1'b1, '0, '0, '0), "R5 zero length");
      // R11 start while active ignored
      do_start(1'b1, 8'd9, 24'd77, 20'd4);
      check("R11 overrun set", 64'(overrun_o), 1);
      check("R11 status kept", 64'(status_o), 64'h80);
      do_chunk(16'd512, mk(F_XFER, 8'h80, 1'b1, 36'd3072, 16'd512, '0), "R11 offset kept R3");
      do_stor(1'b0, mk(F_END, 8'h50, 1'b0, '0, '0, '0), "R7 R6 disk end");
      do_chunk(16'd64, mk(F_WAIT, 8'h50, 1'b0, '0, '0, '0), "R4 wait after end");

      // packet: 3000 bytes at block 3 -> base 6144
      do_start(1'b1, 8'd0, 24'd3, 20'd3000);
      check("R11 overrun cleared", 64'(overrun_o), 0);
      do_chunk(16'd2048, mk(F_XFER, 8'h80, 1'b1, 36'd6144, 16'd2048, '0), "R3 packet offset");
      do_stor(1'b0, mk(F_CHUNK, 8'h80, 1'b1, '0, '0, '0), "R7 packet partial");
      do_chunk(16'd2048, mk(F_XFER, 8'h80, 1'b1, 36'd8192, 16'd2048, '0), "R3 packet index");
      do_stor(1'b1, mk(F_PERR, 8'h41, 1'b0, '0, '0, '0), "R8 packet error");

      // disk error at sector 0
      do_start(1'b0, 8'd1, 24'd0, 20'd0);
      do_chunk(16'd512, mk(F_XFER, 8'h80, 1'b1, 36'd0, 16'd512, '0), "R3 disk zero");
      do_stor(1'b1, mk(F_DERR, 8'h41, 1'b0, '0, '0, '0), "R8 disk error");

      // large address, chunk longer than the remainder (saturation)
      do_start(1'b1, 8'd0, 24'hFFFFFE, 20'd512);
      do_chunk(16'd1024, mk(F_XFER, 8'h80, 1'b1, 36'hFFFFFE << 11, 16'd1024, '0),
               "R3 high offset");
      do_stor(1'b0, mk(F_END, 8'h40, 1'b0, '0, '0, '0), "R6 packet end saturated");

      // R9 no-address packet copies
      do_start(1'b1, 8'd0, 24'hFFFFFF, 20'd100);
      do_chunk(16'd512, mk(F_COPY, 8'h40, 1'b0, '0, '0, 16'd100), "R9 copy clipped");
      do_start(1'b1, 8'd0, 24'hFFFFFF, 20'd300);
      do_chunk(16'd64, mk(F_COPY, 8'h40, 1'b0, '0, '0, 16'd64), "R9 copy chunk len");

      // R6 zero-sector disk ends on first chunk, R12 timing
      do_start(1'b0, 8'd0, 24'd7, 20'd0);
      do_chunk(16'd512, mk(F_END, 8'h50, 1'b0, '0, '0, '0), "R6 R12 immediate end");

      repeat (3) @(negedge clk);
      check("R10 all events seen", 64'(q.size()), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule